// File: doc/BRIEF.md
# Upper-Address Conditioning and Page Register

This block stands between a microcontroller's external bus and the product-term address decoder of a peripheral device. It holds a small page register that the host loads and reads through one offset of its I/O window. The register's bits go straight to the decoder, so the host can switch among up to sixteen pages of memory without a wider address bus.

The block also receives the host's high-order address pins, four of them by default. Two configuration bits set how these pins are treated. The capture bit chooses between two behaviours. In one, each pin is sampled when the address strobe falls and held afterwards. In the other, the pin passes straight through with no register. The route bit chooses where the conditioned pins go. They drive either the address inputs of the bank-select decoder or a set of general logic inputs. Whichever group is not chosen is held at zero. The strobe is sampled on the block clock, and its falling edge is detected between two clock samples.

Top module: `hiaddr_page_unit`

## Requirements
- R1: After reset the page outputs are 0, and in capture mode the upper-address outputs read 0 until the first strobe fall.
- R2: When the chip select is high, the I/O offset equals the page offset (0x18) and write enable is high, the page register takes wdata bits 3..0 at that clock edge. Data bits above bit 3 are ignored.
- R3: A write with the chip select low, or at any offset other than 0x18, leaves the page register unchanged.
- R4: When the chip select, the page offset and read enable are all present, rdata bits 3..0 show the page register combinationally and the upper rdata bits are 0. At all other times rdata is all 0.
- R5: With cfg_latch = 0 (pass-through), the conditioned upper bits follow hi_pin in the same cycle.
- R6: With cfg_latch = 1 (capture), hi_pin is stored at the first clock edge at which ale is sampled low after having been sampled high. The stored value is held at every other edge, whatever hi_pin does.
- R7: With cfg_addr_mode = 1, hi_addr carries the conditioned upper bits and hi_logic is all 0.
- R8: With cfg_addr_mode = 0, hi_logic carries the conditioned upper bits and hi_addr is all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| io_cs | input | 1 | I/O window chip select |
| io_ofs | input | 8 | Offset within the I/O window |
| wr_en | input | 1 | Write strobe, one clock per write |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data |
| ale | input | 1 | Address-latch strobe from the host |
| hi_pin | input | 4 | High-order address pins |
| cfg_latch | input | 1 | 1 = capture on the strobe fall, 0 = pass-through |
| cfg_addr_mode | input | 1 | 1 = route to the bank decoder, 0 = route to logic inputs |
| page | output | 4 | Page register outputs to the decoder |
| hi_addr | output | 4 | Conditioned upper address bits for bank selection |
| hi_logic | output | 4 | Conditioned upper bits as general logic inputs |

## Verification
The bench builds the block with its default parameters: a four-bit page, four upper pins, an eight-bit data bus and page offset 0x18. With an eight-bit bus, the masking of the four upper data bits on both write and read can be observed. With four pins, patterns such as 0x9, 0x6, 0x3 and 0xC give every pin both values in both capture modes and on both routes. Capture timing is checked one edge at a time. The bench confirms that the old value is still present before the strobe fall is seen, and that the new value appears just after it.

// File: rtl/hiaddr_pkg.sv
package hiaddr_pkg;

    // How the upper pins are conditioned before routing.
    typedef enum logic {
        CAP_THRU  = 1'b0,
        CAP_LATCH = 1'b1
    } cap_mode_e;

    // Where the conditioned upper pins are sent.
    typedef enum logic {
        ROUTE_LOGIC = 1'b0,
        ROUTE_ADDR  = 1'b1
    } route_e;

    localparam int unsigned DEF_PAGE_W = 4;
    localparam int unsigned DEF_NUM_HI = 4;
    localparam int unsigned DEF_DATA_W = 8;
    localparam int unsigned DEF_OFS_W  = 8;

endpackage

// File: rtl/hiaddr_page_reg.sv
module hiaddr_page_reg #(
    parameter int unsigned PAGE_W = 4,
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OFS_W  = 8,
    parameter logic [OFS_W-1:0] PAGE_OFS = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_cs,
    input  logic [OFS_W-1:0]  io_ofs,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [PAGE_W-1:0] page
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
    } state_t;

    state_t st_d, st_q;
    logic   hit;
    logic   unused_wdata_hi;

    assign hit             = io_cs && (io_ofs == PAGE_OFS);
    assign unused_wdata_hi = ^wdata[DATA_W-1:PAGE_W];

    always_comb begin
        st_d = st_q;
        if (hit && wr_en) begin
            st_d.page = wdata[PAGE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (hit && rd_en) begin
            rdata[PAGE_W-1:0] = st_q.page;
        end
    end

    assign page = st_q.page;

    // R2: a decoded write lands in the register one edge later
    p_page_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_cs && io_ofs == PAGE_OFS && wr_en) |=> page == $past(wdata[PAGE_W-1:0]));

    // R3: without a decoded write the register keeps its value
    p_page_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_cs && io_ofs == PAGE_OFS && wr_en) |=> $stable(page));

    // R4: the read bus is quiet outside a decoded read
    p_rdata_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_cs && io_ofs == PAGE_OFS && rd_en) |-> rdata == '0);

endmodule

// File: rtl/hiaddr_pin_cond.sv
module hiaddr_pin_cond
    import hiaddr_pkg::*;
#(
    parameter int unsigned NUM_HI = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  cap_mode_e         cap_mode,
    input  logic [NUM_HI-1:0] pins,
    output logic [NUM_HI-1:0] cond
);

    typedef struct packed {
        logic              ale;
        logic [NUM_HI-1:0] held;
    } state_t;

    state_t st_d, st_q;
    logic   strobe_fall;

    assign strobe_fall = st_q.ale && !ale;

    always_comb begin
        st_d     = st_q;
        st_d.ale = ale;
        if (strobe_fall) begin
            st_d.held = pins;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < NUM_HI; i++) begin : g_bit
        assign cond[i] = (cap_mode == CAP_LATCH) ? st_q.held[i] : pins[i];
    end

    // R6: the strobe fall captures the pins
    p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ale && !ale) |=> st_q.held == $past(pins));

    // R6: no strobe fall, no change of the captured bits
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_q.ale && !ale) |=> $stable(st_q.held));

endmodule

// File: rtl/hiaddr_route.sv
module hiaddr_route
    import hiaddr_pkg::*;
#(
    parameter int unsigned NUM_HI = 4
) (
    input  route_e            route,
    input  logic [NUM_HI-1:0] cond,
    output logic [NUM_HI-1:0] hi_addr,
    output logic [NUM_HI-1:0] hi_logic
);

    for (genvar i = 0; i < NUM_HI; i++) begin : g_steer
        assign hi_addr[i]  = (route == ROUTE_ADDR)  && cond[i];
        assign hi_logic[i] = (route == ROUTE_LOGIC) && cond[i];
    end

endmodule

// File: rtl/hiaddr_page_unit.sv
module hiaddr_page_unit
    import hiaddr_pkg::*;
#(
    parameter int unsigned PAGE_W = DEF_PAGE_W,
    parameter int unsigned NUM_HI = DEF_NUM_HI,
    parameter int unsigned DATA_W = DEF_DATA_W,
    parameter int unsigned OFS_W  = DEF_OFS_W,
    parameter logic [OFS_W-1:0] PAGE_OFS = 8'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_cs,
    input  logic [OFS_W-1:0]  io_ofs,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ale,
    input  logic [NUM_HI-1:0] hi_pin,
    input  logic              cfg_latch,
    input  logic              cfg_addr_mode,
    output logic [PAGE_W-1:0] page,
    output logic [NUM_HI-1:0] hi_addr,
    output logic [NUM_HI-1:0] hi_logic
);

    logic [NUM_HI-1:0] cond;
    cap_mode_e         cap_mode;
    route_e            route;

    assign cap_mode = cap_mode_e'(cfg_latch);
    assign route    = route_e'(cfg_addr_mode);

    hiaddr_page_reg #(
        .PAGE_W   (PAGE_W),
        .DATA_W   (DATA_W),
        .OFS_W    (OFS_W),
        .PAGE_OFS (PAGE_OFS)
    ) i_page_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .io_cs  (io_cs),
        .io_ofs (io_ofs),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .wdata  (wdata),
        .rdata  (rdata),
        .page   (page)
    );

    hiaddr_pin_cond #(
        .NUM_HI (NUM_HI)
    ) i_pin_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .ale      (ale),
        .cap_mode (cap_mode),
        .pins     (hi_pin),
        .cond     (cond)
    );

    hiaddr_route #(
        .NUM_HI (NUM_HI)
    ) i_route (
        .route    (route),
        .cond     (cond),
        .hi_addr  (hi_addr),
        .hi_logic (hi_logic)
    );

    // R5: pass-through mode follows the pins
    p_thru_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_latch |-> cond == hi_pin);

    // R7: address route silences the logic inputs
    p_addr_route_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_addr_mode |-> (hi_logic == '0 && hi_addr == cond));

    // R8: logic route silences the bank-decoder inputs
    p_logic_route_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_addr_mode |-> (hi_addr == '0 && hi_logic == cond));

endmodule

// File: tb/test_hiaddr_page_unit.sv
module test_hiaddr_page_unit;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_cs = 1'b0;
    logic [7:0] io_ofs = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ale = 1'b0;
    logic [3:0] hi_pin = '0;
    logic       cfg_latch = 1'b1;
    logic       cfg_addr_mode = 1'b1;
    logic [3:0] page;
    logic [3:0] hi_addr;
    logic [3:0] hi_logic;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hiaddr_page_unit i_hiaddr_page_unit (
        .clk           (clk),
        .rst_n         (rst_n),
        .io_cs         (io_cs),
        .io_ofs        (io_ofs),
        .wr_en         (wr_en),
        .rd_en         (rd_en),
        .wdata         (wdata),
        .rdata         (rdata),
        .ale           (ale),
        .hi_pin        (hi_pin),
        .cfg_latch     (cfg_latch),
        .cfg_addr_mode (cfg_addr_mode),
        .page          (page),
        .hi_addr       (hi_addr),
        .hi_logic      (hi_logic)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // One decoded host write, driven at a falling edge.
    task automatic host_write(input logic cs, input logic [7:0] ofs, input logic [7:0] d);
        @(negedge clk);
        io_cs = cs; io_ofs = ofs; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        io_cs = 1'b0; wr_en = 1'b0;
    endtask

    task automatic host_read(input logic cs, input logic [7:0] ofs, output logic [7:0] d);
        @(negedge clk);
        io_cs = cs; io_ofs = ofs; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        io_cs = 1'b0; rd_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] r;
        @(negedge clk);
        hi_pin = 4'hF;
        #1;
        chk("R1 page after reset", {4'h0, page}, 8'h00);
        chk("R1 captured bits after reset", {4'h0, hi_addr}, 8'h00);
        host_read(1'b1, 8'h18, r);
        chk("R1 read after reset", r, 8'h00);
    endtask

    task automatic t_write_read();
        logic [7:0] r;
        host_write(1'b1, 8'h18, 8'hA5);
        chk("R2 page load upper bits ignored", {4'h0, page}, 8'h05);
        host_read(1'b1, 8'h18, r);
        chk("R4 read shows page", r, 8'h05);
        host_write(1'b1, 8'h18, 8'hFF);
        chk("R2 page load all ones", {4'h0, page}, 8'h0F);
        host_read(1'b1, 8'h18, r);
        chk("R4 read upper bits zero", r, 8'h0F);
    endtask

    task automatic t_write_ignored();
        logic [7:0] r;
        host_write(1'b0, 8'h18, 8'h03);
        chk("R3 write without chip select", {4'h0, page}, 8'h0F);
        host_write(1'b1, 8'h19, 8'h03);
        chk("R3 write at other offset", {4'h0, page}, 8'h0F);
        host_read(1'b1, 8'h10, r);
        chk("R4 read other offset", r, 8'h00);
        host_read(1'b0, 8'h18, r);
        chk("R4 read without chip select", r, 8'h00);
    endtask

    task automatic t_thru();
        @(negedge clk);
        cfg_latch = 1'b0; cfg_addr_mode = 1'b1; hi_pin = 4'h9;
        #1;
        chk("R5 pass-through 0x9", {4'h0, hi_addr}, 8'h09);
        chk("R7 logic silent", {4'h0, hi_logic}, 8'h00);
        hi_pin = 4'h6;
        #1;
        chk("R5 pass-through 0x6", {4'h0, hi_addr}, 8'h06);
    endtask

    task automatic t_capture();
        @(negedge clk);
        cfg_latch = 1'b1; cfg_addr_mode = 1'b1; ale = 1'b1; hi_pin = 4'h3;
        @(negedge clk);
        ale = 1'b0;
        #1;
        chk("R6 old value before fall seen", {4'h0, hi_addr}, 8'h00);
        @(negedge clk);
        chk("R6 captured 0x3", {4'h0, hi_addr}, 8'h03);
        hi_pin = 4'hC;
        @(negedge clk);
        chk("R6 held with ale low", {4'h0, hi_addr}, 8'h03);
        ale = 1'b1;
        @(negedge clk);
        chk("R6 held with ale high", {4'h0, hi_addr}, 8'h03);
        ale = 1'b0;
        @(negedge clk);
        chk("R6 captured 0xC", {4'h0, hi_addr}, 8'h0C);
    endtask

    task automatic t_logic();
        @(negedge clk);
        cfg_addr_mode = 1'b0;
        #1;
        chk("R8 logic carries captured", {4'h0, hi_logic}, 8'h0C);
        chk("R8 address silent", {4'h0, hi_addr}, 8'h00);
        cfg_latch = 1'b0; hi_pin = 4'h5;
        #1;
        chk("R8 logic pass-through", {4'h0, hi_logic}, 8'h05);
        cfg_addr_mode = 1'b1;
        #1;
        chk("R7 address pass-through", {4'h0, hi_addr}, 8'h05);
        chk("R7 logic silent again", {4'h0, hi_logic}, 8'h00);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_write_ignored();
        t_thru();
        t_capture();
        t_logic();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule